// File: doc/BRIEF.md
# Voice Recorder Control Sequencer

This block is the pin-driven controller of a solid-state voice recorder. Four active-low push-button pulses (start, stop, pause, delete) are synchronized and edge-detected. Together with a record/playback select, a ROM-playback select and a 6-bit phrase number, they steer the recorder through its states: power-down, standby, phrase erase, address setup, waiting for voice, running, paused, and a silent gap between chained phrases. The block does no signal processing. It issues command requests to a memory sequencer, reports progress on a busy (monitor) line and a phrase-ready line, and divides the master clock into a sample strobe for the codec.

A phrase run starts with a setup request that carries the latched phrase number. While the memory sequencer streams, the run strobe is high. The sequencer reports the end of a phrase (or a full memory) on an end input. During ROM playback, one more phrase can be queued while phrase-ready is high. That phrase is set up after a gap of a fixed number of sample periods. Before any run is accepted, every phrase must first be erased once with phrase number 0.

Top module: `vrec_ctrl`

## Requirements
- R1: A falling edge on start_n, seen after synchronization, makes a cleared idle block raise mem_req with a setup command: mem_cmd 1 for record, 2 for playback and 3 for ROM playback, with mem_phrase holding the phrase number.
- R2: A falling edge on stop_n during a run, a pause, a voice wait or a gap returns the block to idle, and busy falls.
- R3: A falling edge on pause_n during a run drops mem_run while busy stays high. A start edge in the paused state raises mem_run again without a new setup request.
- R4: rec_sel high selects record and low selects playback. When rom_sel is high, rec_sel is ignored and the setup command is 3.
- R5: A falling edge on del_n while idle raises mem_req with mem_cmd 5 (erase all) when the phrase number is 0. For phrases 1 to 63 it raises mem_cmd 4 (erase one), with mem_phrase equal to the phrase number.
- R6: busy is high from the setup request until the run ends, and mem_run implies busy.
- R7: With vtrig_en high, an acknowledged record setup enters a voice wait in which busy is high and mem_run is low. voice_det starts the recording, and stop returns the block to idle.
- R8: When idle, pwr_up follows idle_stby: low selects power-down (pwr_up 0) and high selects standby (pwr_up 1).
- R9: samp_stb pulses for one cycle every 1024, 768, 640 or 512 clocks for rate_sel 0, 1, 2 or 3, and only while pwr_up is high.
- R10: phrase_rdy is high during a ROM playback run while no phrase is queued. A start edge at that time queues the phrase number. At the end of the phrase, after GAP_STB sample strobes with busy high and mem_run low, a ROM setup for the queued phrase is issued.
- R11: After reset, start edges are ignored until an erase-all has been acknowledged.
- R12: The phrase number and the mode are captured when busy rises, and later changes on phrase or rec_sel do not alter mem_phrase or the run.
- R13: Button edges that arrive while an erase is awaiting its acknowledge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | synchronous active-low reset |
| start_n | input | 1 | start/resume/queue button, active low |
| stop_n | input | 1 | stop button, active low |
| pause_n | input | 1 | pause button, active low |
| del_n | input | 1 | erase button, active low |
| rec_sel | input | 1 | 1 record, 0 playback |
| rom_sel | input | 1 | 1 selects ROM playback |
| phrase | input | 6 | phrase number, 0 means all on erase |
| rate_sel | input | 2 | sample divisor select |
| idle_stby | input | 1 | idle state: 0 power-down, 1 standby |
| vtrig_en | input | 1 | record waits for voice |
| voice_det | input | 1 | voice detected |
| mem_ack | input | 1 | memory sequencer accepted the request |
| mem_end | input | 1 | end of phrase or memory full |
| busy | output | 1 | monitor: operation in progress |
| phrase_rdy | output | 1 | next phrase may be specified |
| pwr_up | output | 1 | 0 while in power-down |
| samp_stb | output | 1 | one-cycle sample strobe |
| mem_req | output | 1 | command request, held until mem_ack |
| mem_cmd | output | 3 | command code (R1, R5) |
| mem_phrase | output | 6 | phrase for the command |
| mem_run | output | 1 | streaming in progress |

## Verification
A wrong state shows first on busy and mem_run. A run stuck in pause or in a voice wait leaves mem_run low while busy stays high, and an early return to idle drops busy. Either error is visible a few cycles after the button edge, once the two-stage synchronizer and edge detector have passed it on. A wrong mode or phrase latch appears on mem_cmd and mem_phrase in the very cycle mem_req rises. A lost or duplicated queued phrase only shows after the gap, one full ROM setup later. The bench therefore counts setup requests across pause, resume and chaining, so that an extra or missing setup is caught.

// File: rtl/vrec_pkg.sv
// Shared types for the voice recorder control sequencer.
// Assumes a 3-bit command field decoded by the memory sequencer.
package vrec_pkg;

    typedef enum logic [2:0] {
        ST_PDOWN = 3'd0,
        ST_STBY  = 3'd1,
        ST_DEL   = 3'd2,
        ST_SETUP = 3'd3,
        ST_VWAIT = 3'd4,
        ST_RUN   = 3'd5,
        ST_PAUSE = 3'd6,
        ST_GAP   = 3'd7
    } vrec_state_e;

    typedef enum logic [1:0] {
        MD_REC  = 2'd0,
        MD_PLAY = 2'd1,
        MD_ROM  = 2'd2
    } vrec_mode_e;

    typedef enum logic [2:0] {
        CMD_NONE      = 3'd0,
        CMD_SET_REC   = 3'd1,
        CMD_SET_PLAY  = 3'd2,
        CMD_SET_ROM   = 3'd3,
        CMD_ERASE_ONE = 3'd4,
        CMD_ERASE_ALL = 3'd5
    } vrec_cmd_e;

endpackage

// File: rtl/vrec_btn_sync.sv
// Button front end: brings NBTN active-low asynchronous buttons into the
// clock domain through two flops and emits a one-cycle pulse on each
// falling edge. Assumes each press stays low for at least two clocks.
module vrec_btn_sync #(
    parameter int NBTN = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NBTN-1:0] btn_n,
    output logic [NBTN-1:0] fall
);

    for (genvar i = 0; i < NBTN; i++) begin : g_btn
        logic [2:0] sh;

        // shift the raw level through the synchronizer and edge history
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= 3'b111;
            else        sh <= {sh[1:0], btn_n[i]};
        end

        assign fall[i] = sh[2] & ~sh[1];
    end

endmodule

// File: rtl/vrec_rate_div.sv
// Sample strobe generator: divides the master clock by 2, 1.5, 1.25 or 1
// times BASE_DIV according to rate_sel. It holds its counter at zero while
// en is low. Assumes BASE_DIV is a multiple of 4.
module vrec_rate_div #(
    parameter int BASE_DIV = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] rate_sel,
    output logic       stb
);

    localparam int CW = $clog2(BASE_DIV * 2);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    // terminal count for the selected divisor
    always_comb begin
        case (rate_sel)
            2'd0:    lim = CW'(BASE_DIV * 2 - 1);
            2'd1:    lim = CW'(BASE_DIV * 3 / 2 - 1);
            2'd2:    lim = CW'(BASE_DIV * 5 / 4 - 1);
            default: lim = CW'(BASE_DIV - 1);
        endcase
    end

    // free-running counter, wraps at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  cnt <= '0;
        else if (cnt >= lim) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign stb = en && (cnt == lim);

endmodule

// File: rtl/vrec_seq.sv
// Main control state machine. It accepts edge pulses from the button
// front end, issues setup and erase requests that are held until mem_ack,
// and tracks runs, pauses, voice waits and ROM phrase chaining.
// Assumes mem_ack and mem_end are one-cycle pulses from the memory side.
module vrec_seq
    import vrec_pkg::*;
#(
    parameter int PH_W    = 6,
    parameter int GAP_STB = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            halt,
    input  logic            hold,
    input  logic            erase,
    input  logic            rec_sel,
    input  logic            rom_sel,
    input  logic [PH_W-1:0] phrase,
    input  logic            idle_stby,
    input  logic            vtrig_en,
    input  logic            voice_det,
    input  logic            mem_ack,
    input  logic            mem_end,
    input  logic            stb,
    output logic            busy,
    output logic            phrase_rdy,
    output logic            pwr_up,
    output logic            mem_req,
    output logic [2:0]      mem_cmd,
    output logic [PH_W-1:0] mem_phrase,
    output logic            mem_run,
    output logic            all_clr
);

    localparam int GCW = $clog2(GAP_STB + 1);

    vrec_state_e     st;
    vrec_mode_e      mode;
    logic            er_all;
    logic [PH_W-1:0] ph_q;
    logic            q_valid;
    logic [PH_W-1:0] q_ph;
    logic            clr_q;
    logic [GCW-1:0]  gap_cnt;
    vrec_state_e     idle_st;

    // idle target chosen by the idle-mode select
    assign idle_st = idle_stby ? ST_STBY : ST_PDOWN;

    // state, latched run parameters and phrase queue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_PDOWN;
            mode    <= MD_PLAY;
            er_all  <= 1'b0;
            ph_q    <= '0;
            q_valid <= 1'b0;
            q_ph    <= '0;
            clr_q   <= 1'b0;
            gap_cnt <= '0;
        end else begin
            case (st)
                ST_PDOWN, ST_STBY: begin
                    if (erase) begin
                        st     <= ST_DEL;
                        er_all <= (phrase == '0);
                        ph_q   <= phrase;
                    end else if (go && clr_q) begin
                        st      <= ST_SETUP;
                        mode    <= rom_sel ? MD_ROM : (rec_sel ? MD_REC : MD_PLAY);
                        ph_q    <= phrase;
                        q_valid <= 1'b0;
                    end else begin
                        st <= idle_st;
                    end
                end
                ST_DEL: begin
                    if (mem_ack) begin
                        st <= idle_st;
                        if (er_all) clr_q <= 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (mem_ack)
                        st <= (mode == MD_REC && vtrig_en) ? ST_VWAIT : ST_RUN;
                end
                ST_VWAIT: begin
                    if (halt)           st <= idle_st;
                    else if (voice_det) st <= ST_RUN;
                end
                ST_RUN: begin
                    if (halt) begin
                        st      <= idle_st;
                        q_valid <= 1'b0;
                    end else if (hold) begin
                        st <= ST_PAUSE;
                    end else if (mem_end) begin
                        if (mode == MD_ROM && q_valid) begin
                            st      <= ST_GAP;
                            gap_cnt <= '0;
                        end else begin
                            st <= idle_st;
                        end
                    end else if (go && mode == MD_ROM && !q_valid) begin
                        q_valid <= 1'b1;
                        q_ph    <= phrase;
                    end
                end
                ST_PAUSE: begin
                    if (halt) begin
                        st      <= idle_st;
                        q_valid <= 1'b0;
                    end else if (go) begin
                        st <= ST_RUN;
                    end
                end
                default: begin // ST_GAP
                    if (halt) begin
                        st      <= idle_st;
                        q_valid <= 1'b0;
                    end else if (stb) begin
                        if (gap_cnt == GCW'(GAP_STB - 1)) begin
                            st      <= ST_SETUP;
                            ph_q    <= q_ph;
                            q_valid <= 1'b0;
                        end else begin
                            gap_cnt <= gap_cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // command code presented with the request
    always_comb begin
        mem_cmd = CMD_NONE;
        if (st == ST_DEL)
            mem_cmd = er_all ? CMD_ERASE_ALL : CMD_ERASE_ONE;
        else if (st == ST_SETUP) begin
            case (mode)
                MD_REC:  mem_cmd = CMD_SET_REC;
                MD_PLAY: mem_cmd = CMD_SET_PLAY;
                default: mem_cmd = CMD_SET_ROM;
            endcase
        end
    end

    assign busy       = (st == ST_SETUP) || (st == ST_VWAIT) || (st == ST_RUN) ||
                        (st == ST_PAUSE) || (st == ST_GAP);
    assign pwr_up     = (st != ST_PDOWN);
    assign mem_req    = (st == ST_SETUP) || (st == ST_DEL);
    assign mem_run    = (st == ST_RUN);
    assign phrase_rdy = (st == ST_RUN) && (mode == MD_ROM) && !q_valid;
    assign mem_phrase = ph_q;
    assign all_clr    = clr_q;

endmodule

// File: rtl/vrec_ctrl.sv
// Top of the voice recorder control sequencer: button synchronizers,
// sample-rate divider and main state machine. Assumes buttons are
// asynchronous, active low and held low for at least two clocks.
module vrec_ctrl #(
    parameter int PH_W     = 6,
    parameter int BASE_DIV = 512,
    parameter int GAP_STB  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_n,
    input  logic            stop_n,
    input  logic            pause_n,
    input  logic            del_n,
    input  logic            rec_sel,
    input  logic            rom_sel,
    input  logic [PH_W-1:0] phrase,
    input  logic [1:0]      rate_sel,
    input  logic            idle_stby,
    input  logic            vtrig_en,
    input  logic            voice_det,
    input  logic            mem_ack,
    input  logic            mem_end,
    output logic            busy,
    output logic            phrase_rdy,
    output logic            pwr_up,
    output logic            samp_stb,
    output logic            mem_req,
    output logic [2:0]      mem_cmd,
    output logic [PH_W-1:0] mem_phrase,
    output logic            mem_run
);

    localparam int NBTN = 4;

    logic [NBTN-1:0] fall;
    logic            all_clr;

    vrec_btn_sync #(.NBTN(NBTN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .btn_n ({del_n, pause_n, stop_n, start_n}),
        .fall  (fall)
    );

    vrec_rate_div #(.BASE_DIV(BASE_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pwr_up),
        .rate_sel (rate_sel),
        .stb      (samp_stb)
    );

    vrec_seq #(.PH_W(PH_W), .GAP_STB(GAP_STB)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (fall[0]),
        .halt       (fall[1]),
        .hold       (fall[2]),
        .erase      (fall[3]),
        .rec_sel    (rec_sel),
        .rom_sel    (rom_sel),
        .phrase     (phrase),
        .idle_stby  (idle_stby),
        .vtrig_en   (vtrig_en),
        .voice_det  (voice_det),
        .mem_ack    (mem_ack),
        .mem_end    (mem_end),
        .stb        (samp_stb),
        .busy       (busy),
        .phrase_rdy (phrase_rdy),
        .pwr_up     (pwr_up),
        .mem_req    (mem_req),
        .mem_cmd    (mem_cmd),
        .mem_phrase (mem_phrase),
        .mem_run    (mem_run),
        .all_clr    (all_clr)
    );

endmodule

// File: rtl/vrec_ctrl_chk.sv
// Property checker for vrec_ctrl, attached by bind below.
module vrec_ctrl_chk #(
    parameter int PH_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            mem_run,
    input logic            phrase_rdy,
    input logic            pwr_up,
    input logic            mem_req,
    input logic [2:0]      mem_cmd,
    input logic [PH_W-1:0] mem_phrase,
    input logic            samp_stb,
    input logic            all_clr
);

    // R6
    run_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_run |-> busy);

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |=> !samp_stb);

    // R9
    stb_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        samp_stb |-> pwr_up);

    // R10
    rdy_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phrase_rdy |-> (busy && mem_run));

    // R11
    start_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> all_clr);

    // R5
    erase_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_cmd == 3'd5 || mem_cmd == 3'd4)) |-> !busy);

    // R12
    phrase_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_run && $past(mem_run)) |-> $stable(mem_phrase));

endmodule

bind vrec_ctrl vrec_ctrl_chk #(.PH_W(PH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .mem_run    (mem_run),
    .phrase_rdy (phrase_rdy),
    .pwr_up     (pwr_up),
    .mem_req    (mem_req),
    .mem_cmd    (mem_cmd),
    .mem_phrase (mem_phrase),
    .samp_stb   (samp_stb),
    .all_clr    (all_clr)
);

// File: tb/tb_vrec_ctrl.sv
module tb_vrec_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn_n = 4'hF;   // 0 start, 1 stop, 2 pause, 3 delete
    logic       rec_sel = 1'b0, rom_sel = 1'b0, idle_stby = 1'b0;
    logic       vtrig_en = 1'b0, voice_det = 1'b0, mem_ack = 1'b0, mem_end = 1'b0;
    logic [5:0] phrase = '0;
    logic [1:0] rate_sel = 2'd3;
    logic       busy, phrase_rdy, pwr_up, samp_stb, mem_req, mem_run;
    logic [2:0] mem_cmd;
    logic [5:0] mem_phrase;

    int checks = 0, errors = 0;
    int ack_dly = 3;
    int req_cnt = 0;
    logic [2:0] last_cmd = '0;
    logic [5:0] last_ph = '0;
    logic req_prev = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    vrec_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .start_n(btn_n[0]), .stop_n(btn_n[1]), .pause_n(btn_n[2]), .del_n(btn_n[3]),
        .rec_sel(rec_sel), .rom_sel(rom_sel), .phrase(phrase), .rate_sel(rate_sel),
        .idle_stby(idle_stby), .vtrig_en(vtrig_en), .voice_det(voice_det),
        .mem_ack(mem_ack), .mem_end(mem_end),
        .busy(busy), .phrase_rdy(phrase_rdy), .pwr_up(pwr_up), .samp_stb(samp_stb),
        .mem_req(mem_req), .mem_cmd(mem_cmd), .mem_phrase(mem_phrase), .mem_run(mem_run)
    );

    // rate_sel stimulus and expected strobe period
    localparam logic [13:0] RATE_VEC [0:3] = '{
        {2'd0, 12'd1024}, {2'd1, 12'd768}, {2'd2, 12'd640}, {2'd3, 12'd512}
    };

    // memory sequencer model: acknowledge each request after ack_dly cycles
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                repeat (ack_dly) @(negedge clk);
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end
        end
    end

    // request monitor: capture command and phrase when mem_req rises
    always @(negedge clk) begin
        if (mem_req && !req_prev) begin
            req_cnt  = req_cnt + 1;
            last_cmd = mem_cmd;
            last_ph  = mem_phrase;
        end
        req_prev = mem_req;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic press(input int b);
        @(negedge clk);
        btn_n[b] = 1'b0;
        repeat (3) @(negedge clk);
        btn_n[b] = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic pulse_end();
        @(negedge clk);
        mem_end = 1'b1;
        @(negedge clk);
        mem_end = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int rc;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // reset state
        check("R6 reset busy", busy, 0);
        check("R1 reset mem_req", mem_req, 0);
        check("R8 reset pwr_up (idle low)", pwr_up, 0);
        check("R10 reset phrase_rdy", phrase_rdy, 0);

        // R11: start before erase-all is ignored
        rec_sel = 1'b1; phrase = 6'd3;
        press(0);
        repeat (10) @(negedge clk);
        check("R11 start refused busy", busy, 0);
        check("R11 start refused req", req_cnt, 0);

        // R5 erase all, R13 start during erase ignored
        ack_dly = 40; phrase = 6'd0;
        press(3);
        check("R5 erase-all cmd", last_cmd, 5);
        press(0);
        repeat (50) @(negedge clk);
        check("R13 start during erase busy", busy, 0);
        check("R13 start during erase req", req_cnt, 1);
        ack_dly = 3;

        // R5 erase one
        phrase = 6'd5;
        press(3);
        repeat (5) @(negedge clk);
        check("R5 erase-one cmd", last_cmd, 4);
        check("R5 erase-one phrase", last_ph, 5);

        // R8 idle modes
        idle_stby = 1'b1;
        repeat (5) @(negedge clk);
        check("R8 standby pwr_up", pwr_up, 1);
        idle_stby = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 power-down pwr_up", pwr_up, 0);

        // R1/R4 record
        rec_sel = 1'b1; phrase = 6'd9;
        press(0);
        check("R1 record cmd", last_cmd, 1);
        check("R1 record phrase", last_ph, 9);
        check("R6 busy in record", busy, 1);
        check("R1 run after ack", mem_run, 1);
        // R12 later input changes ignored
        phrase = 6'd20; rec_sel = 1'b0;
        repeat (5) @(negedge clk);
        check("R12 phrase held", mem_phrase, 9);
        // R3 pause and resume
        press(2);
        check("R3 paused run", mem_run, 0);
        check("R3 paused busy", busy, 1);
        rc = req_cnt;
        press(0);
        check("R3 resumed run", mem_run, 1);
        check("R3 no new setup", req_cnt, rc);
        // R2 stop
        press(1);
        check("R2 stop busy", busy, 0);
        check("R8 back to power-down", pwr_up, 0);

        // R4 playback, end of phrase
        rec_sel = 1'b0; phrase = 6'd7;
        press(0);
        check("R4 playback cmd", last_cmd, 2);
        pulse_end();
        check("R6 playback end busy", busy, 0);

        // R4/R10 ROM playback with chained phrase
        rom_sel = 1'b1; rec_sel = 1'b1; phrase = 6'd12;
        press(0);
        check("R4 rom cmd ignores rec_sel", last_cmd, 3);
        check("R10 phrase_rdy in rom run", phrase_rdy, 1);
        phrase = 6'd33;
        press(0);
        check("R10 queued clears ready", phrase_rdy, 0);
        check("R12 current phrase kept", mem_phrase, 12);
        rc = req_cnt;
        pulse_end();
        check("R10 gap busy", busy, 1);
        check("R10 gap silent", mem_run, 0);
        for (int i = 0; i < 4000 && req_cnt == rc; i++) @(negedge clk);
        check("R10 chained cmd", last_cmd, 3);
        check("R10 chained phrase", last_ph, 33);
        repeat (10) @(negedge clk);
        check("R10 chained run", mem_run, 1);
        check("R10 ready again", phrase_rdy, 1);
        pulse_end();
        check("R10 chain end busy", busy, 0);

        // R7 voice trigger
        rom_sel = 1'b0; rec_sel = 1'b1; vtrig_en = 1'b1; phrase = 6'd2;
        press(0);
        check("R7 wait busy", busy, 1);
        check("R7 wait no run", mem_run, 0);
        voice_det = 1'b1;
        repeat (3) @(negedge clk);
        voice_det = 1'b0;
        check("R7 voice starts run", mem_run, 1);
        press(1);
        check("R2 stop after voice", busy, 0);
        press(0);
        check("R7 second wait", mem_run, 0);
        press(1);
        check("R7 stop in wait", busy, 0);
        vtrig_en = 1'b0;

        // R9 sample strobe table
        idle_stby = 1'b1;
        repeat (5) @(negedge clk);
        foreach (RATE_VEC[k]) begin
            int per;
            rate_sel = RATE_VEC[k][13:12];
            for (int s = 0; s < 2; s++) begin
                @(negedge clk);
                while (!samp_stb) @(negedge clk);
            end
            per = 0;
            do begin
                @(negedge clk);
                per++;
            end while (!samp_stb);
            check($sformatf("R9 period sel=%0d", rate_sel), per, int'(RATE_VEC[k][11:0]));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule